// File: doc/BRIEF.md
# Serial DAC Command and Register Control

This block is the digital control core of a serial-loaded voltage-output converter. A companion front end shifts in a 16-bit word and pulses a one-cycle strobe when the word is complete. This block decodes that word and keeps two 12-bit registers: a staging register and the code register that drives the converter ladder. The two can be written separately or together. It also holds a sleep state, a general-purpose logic output and a flag that picks which serial clock edge the companion uses to shift readback data out.

Four board-level pins act on the core: an active-low clear, a sleep request, a sleep-permit (lockout) pin and a strap that picks the clear level. All four are synchronized to the system clock inside the block. Clearing and reset both load the registers with zero or with midscale, as the strap selects. Sleep has no effect unless the permit pin is high. Releasing the sleep request does not wake the block. It wakes only on a falling edge of the permit pin or on a command that updates the code register. The code held before sleep is kept, so it returns on wake.

Top module: `dac_cmd_core`

## Requirements
- R1: The word is read MSB first as follows. Bits [15:14] are the command. Bits [13:2] are the 12-bit data, with bit 13 as the MSB. Bits [1:0] are ignored. A word acts only in a cycle where `word_vld` is high, and its effects show at the outputs after the next clock edge.
- R2: Command 00 writes the data to the staging register and leaves `dac_code` unchanged.
- R3: Command 01 writes the data to the staging register and to `dac_code` at the same time.
- R4: Command 10 copies the staging register into `dac_code`.
- R5: Command 11 uses word bits [13:11] as a sub-command. Values 000 and 001 do nothing. Values 010 and 011 request sleep.
- R6: Sub-command 100 drives `user_out` low and 101 drives it high.
- R7: Sub-command 110 sets `dout_late` to 1 and 111 sets it to 0. The flag changes on no other event.
- R8: Sleep (`out_en` low) is entered by the sleep command or by `sleep_req` high, but only while `sleep_lock` is high. With `sleep_lock` low, both paths are ignored.
- R9: Sleep ends only on a falling edge of `sleep_lock` or on a command 01 or 10. If sleep is requested in the same cycle as a wake condition, the request wins. Lowering `sleep_req` does not end sleep. While asleep, words are still accepted and both registers keep their contents.
- R10: While `clear_n` is low, both registers load 0x000 if `mid_rst` is low, or 0x800 if it is high, and `user_out` goes low. This overrides any register or `user_out` effect of a word in the same cycle. The sleep and `dout_late` effects of that word still apply.
- R11: After reset, both registers hold the clear level picked by `mid_rst`, `out_en` is 1, `user_out` is 0 and `dout_late` is 0.
- R12: Each pin passes through SYNC_STAGES (default 2) flip-flops. A pin change therefore reaches the outputs on the (SYNC_STAGES+1)-th clock edge after it is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| word_vld | input | 1 | One-cycle strobe that marks a complete word |
| word_in | input | 16 | Command word from the serial front end |
| clear_n | input | 1 | Asynchronous clear request, active low |
| sleep_req | input | 1 | Asynchronous sleep request, active high |
| sleep_lock | input | 1 | Sleep permit; a falling edge wakes the block |
| mid_rst | input | 1 | Clear and reset level select: 0 gives zero, 1 gives midscale |
| dac_code | output | 12 | Code driven to the converter |
| out_en | output | 1 | Low while asleep |
| user_out | output | 1 | General-purpose logic output |
| dout_late | output | 1 | Readback edge select flag |

## Verification
Two collisions matter most. The first is a word strobe that lands while the synchronized clear is active. The second is an update command that arrives while a sleep request is still being held. The bench provokes the first by holding `clear_n` low across a load-both strobe and a user-output-high command. It then checks that the code stays at the clear level and `user_out` stays low. It provokes the second by keeping `sleep_req` and `sleep_lock` high while it sends command 10, and checks that `out_en` stays low. A behavioural model with its own pin-delay queues is compared with all outputs on every clock, so a wrong priority shows up in the exact cycle it occurs.

// File: rtl/dac_cmd_pkg.sv
package dac_cmd_pkg;

  typedef enum logic [1:0] {
    CT_STAGE  = 2'b00,
    CT_BOTH   = 2'b01,
    CT_COPY   = 2'b10,
    CT_MISC   = 2'b11
  } ctrl_e;

  // Decoded actions of one strobed word, already gated by the strobe.
  typedef struct packed {
    logic load_stage;
    logic load_code;
    logic copy_stage;
    logic sleep_cmd;
    logic upo_set;
    logic upo_val;
    logic mode_set;
    logic mode_val;
  } cmd_t;

endpackage

// File: rtl/dac_pin_sync.sv
module dac_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  output logic pin_s
);
  logic [STAGES-1:0] sh;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) sh <= pin;
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) sh <= {STAGES{pin}};
        else     sh <= {sh[STAGES-2:0], pin};
      end
    end
  endgenerate

  assign pin_s = sh[STAGES-1];
endmodule

// File: rtl/dac_cmd_decode.sv
module dac_cmd_decode
  import dac_cmd_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              vld,
  input  logic [1:0]        ctrl,
  input  logic [DATA_W-1:0] data,
  output cmd_t              cmd
);
  logic [2:0] sub;
  assign sub = data[DATA_W-1 -: 3];

  always_comb begin
    cmd = '0;
    if (vld) begin
      unique case (ctrl_e'(ctrl))
        CT_STAGE: cmd.load_stage = 1'b1;
        CT_BOTH: begin
          cmd.load_stage = 1'b1;
          cmd.load_code  = 1'b1;
        end
        CT_COPY: cmd.copy_stage = 1'b1;
        CT_MISC: begin
          unique casez (sub)
            3'b00?: ;
            3'b01?: cmd.sleep_cmd = 1'b1;
            3'b10?: begin
              cmd.upo_set = 1'b1;
              cmd.upo_val = sub[0];
            end
            default: begin
              cmd.mode_set = 1'b1;
              cmd.mode_val = ~sub[0];
            end
          endcase
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/dac_reg_pair.sv
module dac_reg_pair #(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_act,
  input  logic [DATA_W-1:0] clr_val,
  input  logic              load_stage,
  input  logic              load_code,
  input  logic              copy_stage,
  input  logic [DATA_W-1:0] data,
  output logic [DATA_W-1:0] code_q
);
  logic [DATA_W-1:0] stage_q;

  always_ff @(posedge clk) begin
    if (rst || clr_act) begin
      stage_q <= clr_val;
      code_q  <= clr_val;
    end else begin
      if (load_stage) stage_q <= data;
      if (load_code)       code_q <= data;
      else if (copy_stage) code_q <= stage_q;
    end
  end
endmodule

// File: rtl/dac_cmd_core.sv
module dac_cmd_core
  import dac_cmd_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int DATA_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              word_vld,
  input  logic [WORD_W-1:0] word_in,
  input  logic              clear_n,
  input  logic              sleep_req,
  input  logic              sleep_lock,
  input  logic              mid_rst,
  output logic [DATA_W-1:0] dac_code,
  output logic              out_en,
  output logic              user_out,
  output logic              dout_late
);
  localparam int NPINS = 4;
  localparam int SUB_W = WORD_W - 2 - DATA_W;
  localparam logic [DATA_W-1:0] MID = DATA_W'(1) << (DATA_W - 1);

  logic [NPINS-1:0] pin_raw, pin_s;
  assign pin_raw = {sleep_lock, sleep_req, clear_n, mid_rst};

  generate
    for (genvar i = 0; i < NPINS; i++) begin : g_sync
      dac_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .pin(pin_raw[i]), .pin_s(pin_s[i])
      );
    end
  endgenerate

  logic              lock_s, sleep_s, clr_act, lock_q, lock_fall;
  logic [DATA_W-1:0] clr_val;
  assign lock_s    = pin_s[3];
  assign sleep_s   = pin_s[2];
  assign clr_act   = ~pin_s[1];
  assign clr_val   = pin_s[0] ? MID : '0;
  assign lock_fall = lock_q & ~lock_s;

  logic unused_sub;
  assign unused_sub = ^word_in[SUB_W-1:0];

  cmd_t              cmd;
  logic [DATA_W-1:0] wdata;
  assign wdata = word_in[WORD_W-3 -: DATA_W];

  dac_cmd_decode #(.DATA_W(DATA_W)) u_dec (
    .vld(word_vld), .ctrl(word_in[WORD_W-1 -: 2]), .data(wdata), .cmd(cmd)
  );

  dac_reg_pair #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .clr_act(clr_act), .clr_val(clr_val),
    .load_stage(cmd.load_stage), .load_code(cmd.load_code),
    .copy_stage(cmd.copy_stage), .data(wdata), .code_q(dac_code)
  );

  logic asleep;
  always_ff @(posedge clk) begin
    if (rst) begin
      asleep    <= 1'b0;
      user_out  <= 1'b0;
      dout_late <= 1'b0;
      lock_q    <= sleep_lock;
    end else begin
      lock_q <= lock_s;
      if (clr_act)          user_out <= 1'b0;
      else if (cmd.upo_set) user_out <= cmd.upo_val;
      if (cmd.mode_set) dout_late <= cmd.mode_val;
      if (lock_s && (sleep_s || cmd.sleep_cmd))
        asleep <= 1'b1;
      else if (lock_fall || cmd.load_code || cmd.copy_stage)
        asleep <= 1'b0;
    end
  end

  assign out_en = ~asleep;
endmodule

// File: rtl/dac_cmd_core_chk.sv
module dac_cmd_core_chk #(
  parameter int DATA_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              word_vld,
  input logic [1:0]        ctrl,
  input logic [DATA_W-1:0] dac_code,
  input logic              out_en,
  input logic              user_out,
  input logic              dout_late,
  input logic              lock_s,
  input logic              sleep_s,
  input logic              clr_act,
  input logic              lock_fall,
  input logic [DATA_W-1:0] clr_val
);
  // R1
  code_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!word_vld && !clr_act) |=> $stable(dac_code));

  // R7
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !word_vld |=> $stable(dout_late));

  // R8
  lockout_chk: assert property (@(posedge clk) disable iff (rst)
    (!lock_s && out_en) |=> out_en);

  // R8
  pin_sleep_chk: assert property (@(posedge clk) disable iff (rst)
    (lock_s && sleep_s) |=> !out_en);

  // R9
  sleep_stay_chk: assert property (@(posedge clk) disable iff (rst)
    (!out_en && !lock_fall && !(word_vld && (ctrl == 2'b01 || ctrl == 2'b10)))
      |=> !out_en);

  // R10
  clear_chk: assert property (@(posedge clk) disable iff (rst)
    clr_act |=> (dac_code == $past(clr_val)) && !user_out);
endmodule

bind dac_cmd_core dac_cmd_core_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .word_vld(word_vld), .ctrl(word_in[WORD_W-1 -: 2]),
  .dac_code(dac_code), .out_en(out_en), .user_out(user_out),
  .dout_late(dout_late), .lock_s(lock_s), .sleep_s(sleep_s),
  .clr_act(clr_act), .lock_fall(lock_fall), .clr_val(clr_val)
);

// File: tb/sim_dac_cmd_core.sv
module sim_dac_cmd_core;
  localparam int ST = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        word_vld = 1'b0;
  logic [15:0] word_in = '0;
  logic        clear_n = 1'b1, sleep_req = 1'b0, sleep_lock = 1'b1, mid_rst = 1'b1;
  logic [11:0] dac_code;
  logic        out_en, user_out, dout_late;

  int vectors = 0, fails = 0, cycles = 0;
  string phase = "R11";

  dac_cmd_core u0 (
    .clk(clk), .rst(rst), .word_vld(word_vld), .word_in(word_in),
    .clear_n(clear_n), .sleep_req(sleep_req), .sleep_lock(sleep_lock),
    .mid_rst(mid_rst), .dac_code(dac_code), .out_en(out_en),
    .user_out(user_out), .dout_late(dout_late)
  );

  always #10 clk = ~clk;

  // Reference model: pins delayed by a queue, then the requirements applied.
  logic [3:0]  dq[$];
  logic        m_prev, m_sleep, m_upo, m_late;
  logic [11:0] m_stage, m_code;

  always @(posedge clk) begin
    logic [3:0]  u;
    logic [11:0] cv, d, n_stage, n_code;
    logic        fall, wake, req;
    if (rst) begin
      dq.delete();
      for (int i = 0; i < ST; i++) dq.push_back({sleep_lock, sleep_req, clear_n, mid_rst});
      m_prev  = sleep_lock;
      cv      = mid_rst ? 12'h800 : 12'h000;
      m_stage = cv; m_code = cv;
      m_sleep = 0; m_upo = 0; m_late = 0;
    end else begin
      u = dq.pop_front();
      dq.push_back({sleep_lock, sleep_req, clear_n, mid_rst});
      cv   = u[0] ? 12'h800 : 12'h000;
      fall = m_prev && !u[3];
      m_prev = u[3];
      d = word_in[13:2];
      n_stage = m_stage; n_code = m_code;
      wake = 0; req = 0;
      if (word_vld) begin
        case (word_in[15:14])
          2'd0: n_stage = d;
          2'd1: begin n_stage = d; n_code = d; wake = 1; end
          2'd2: begin n_code = m_stage; wake = 1; end
          default: begin
            case (d[11:9])
              3'd2, 3'd3: req = 1;
              3'd4: m_upo = 0;
              3'd5: m_upo = 1;
              3'd6: m_late = 1;
              3'd7: m_late = 0;
              default: ;
            endcase
          end
        endcase
      end
      if (!u[1]) begin n_stage = cv; n_code = cv; m_upo = 0; end
      m_stage = n_stage; m_code = n_code;
      if (u[3] && (u[2] || req)) m_sleep = 1;
      else if (fall || wake)     m_sleep = 0;
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      vectors++;
      if (dac_code !== m_code || out_en !== !m_sleep ||
          user_out !== m_upo || dout_late !== m_late) begin
        fails++;
        $display("FAIL %s: got code=%h en=%b upo=%b late=%b exp code=%h en=%b upo=%b late=%b",
                 phase, dac_code, out_en, user_out, dout_late,
                 m_code, !m_sleep, m_upo, m_late);
      end
    end
    if (cycles > 100000) begin
      fails++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(logic [1:0] c, logic [11:0] d, logic [1:0] s);
    @(negedge clk);
    word_in = {c, d, s}; word_vld = 1'b1;
    @(negedge clk);
    word_vld = 1'b0;
  endtask

  task automatic direct(string tag, logic [11:0] code, logic en, logic upo);
    vectors++;
    if (dac_code !== code || out_en !== en || user_out !== upo) begin
      fails++;
      $display("FAIL %s: got code=%h en=%b upo=%b exp code=%h en=%b upo=%b",
               tag, dac_code, out_en, user_out, code, en, upo);
    end
  endtask

  initial begin
    idle(4);
    rst = 1'b0;
    idle(1);
    direct("R11", 12'h800, 1'b1, 1'b0);

    phase = "R2";  send(2'b00, 12'h123, 2'b00); idle(2);
    direct("R2", 12'h800, 1'b1, 1'b0);
    phase = "R4";  send(2'b10, 12'h000, 2'b00); idle(2);
    direct("R4", 12'h123, 1'b1, 1'b0);
    phase = "R1";  word_in = {2'b01, 12'hFFF, 2'b11}; idle(4);
    direct("R1", 12'h123, 1'b1, 1'b0);
    phase = "R3";  send(2'b01, 12'hABC, 2'b11); idle(2);
    direct("R3", 12'hABC, 1'b1, 1'b0);
    phase = "R6";  send(2'b11, 12'hA00, 2'b00); idle(2);
    direct("R6", 12'hABC, 1'b1, 1'b1);
    send(2'b11, 12'h800, 2'b00); idle(2);
    phase = "R7";  send(2'b11, 12'hC00, 2'b00); idle(2);
    send(2'b11, 12'hE00, 2'b00); send(2'b11, 12'hC00, 2'b00); idle(2);
    phase = "R5";  send(2'b11, 12'h000, 2'b00); send(2'b11, 12'h200, 2'b00); idle(2);
    send(2'b11, 12'h400, 2'b00); idle(2);
    direct("R5", 12'hABC, 1'b0, 1'b0);
    phase = "R9";  send(2'b00, 12'h555, 2'b00); idle(3);
    direct("R9", 12'hABC, 1'b0, 1'b0);
    send(2'b10, 12'h000, 2'b00); idle(2);
    direct("R9", 12'h555, 1'b1, 1'b0);
    phase = "R8";  sleep_lock = 1'b0; idle(5);
    sleep_req = 1'b1; idle(5);
    send(2'b11, 12'h600, 2'b00); idle(3);
    direct("R8", 12'h555, 1'b1, 1'b0);
    phase = "R12"; sleep_lock = 1'b1; idle(5);
    direct("R12", 12'h555, 1'b0, 1'b0);
    phase = "R9";  sleep_req = 1'b0; idle(6);
    send(2'b10, 12'h000, 2'b00); sleep_req = 1'b1; idle(1);
    sleep_req = 1'b0; idle(5);
    send(2'b01, 12'h321, 2'b00); idle(1);
    sleep_req = 1'b1; idle(3); sleep_req = 1'b0;
    send(2'b10, 12'h000, 2'b00); sleep_req = 1'b1; send(2'b10, 12'h000, 2'b00);
    idle(2);
    direct("R9", 12'h321, 1'b0, 1'b0);
    sleep_req = 1'b0; idle(4);
    sleep_lock = 1'b0; idle(5);
    direct("R9", 12'h321, 1'b1, 1'b0);
    sleep_lock = 1'b1; idle(4);
    phase = "R10"; send(2'b11, 12'hA00, 2'b00); mid_rst = 1'b0; idle(4);
    clear_n = 1'b0; idle(4);
    send(2'b01, 12'h777, 2'b00); send(2'b11, 12'hA00, 2'b00);
    send(2'b11, 12'hC00, 2'b00); idle(1);
    direct("R10", 12'h000, 1'b1, 1'b0);
    clear_n = 1'b1; idle(4);
    send(2'b10, 12'h000, 2'b00); idle(2);
    direct("R10", 12'h000, 1'b1, 1'b0);
    mid_rst = 1'b1; send(2'b01, 12'h0F0, 2'b00); idle(3);
    clear_n = 1'b0; idle(1); clear_n = 1'b1; idle(5);
    direct("R10", 12'h800, 1'b1, 1'b0);
    phase = "R11"; mid_rst = 1'b0; idle(3); rst = 1'b1; idle(3); rst = 1'b0; idle(1);
    direct("R11", 12'h000, 1'b1, 1'b0);
    idle(3);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule